// File: doc/BRIEF.md
# I2C Target Controller with Byte-Event Backend Port

This block is the target side of an I2C bus. It watches the SCL and SDA lines and recognises START, repeated START and STOP conditions. It compares each address byte with a configured 7-bit address and takes part in a transfer only when that address matches. While it takes part, it pulls SDA low for acknowledges and for outgoing data bits. Every pull-down is open-drain: the block only drives a line low or releases it.

Byte handling is left to a backend, which sees a narrow event port. A transfer produces a short series of events: a write request, a read request, a byte received, a request for the next byte to send, and a stop. The backend answers each event with a valid/ready handshake. The answer carries the byte to transmit, or an accept/reject flag for the byte just received. When the bus reaches a point that needs an answer the backend has not yet given, the block holds SCL low.

During a read, the next byte is fetched while the current byte is still being shifted out, so bytes leave back to back. If the master rejects a byte and ends the read, the byte already fetched is dropped without any further event.

Top module: `i2c_tgt_evt`

## Requirements
- R1: After reset, `sda_pull`, `scl_pull` and `ev_valid` are all low.
- R2: When the address byte matches `own_addr` with the direction bit 0 (write), the block raises event code 0 and pulls SDA low during the ninth clock. This acknowledge does not depend on the backend.
- R3: When the address matches with the direction bit 1 (read), the block raises event code 1. It acknowledges the address, then sends the byte the backend returned, most significant bit first.
- R4: After each complete byte written by the master, the block raises event code 2 with that byte on `ev_data`. In the ninth clock it pulls SDA low if `bk_nack` was 0 at acceptance, and leaves SDA released if `bk_nack` was 1.
- R5: Each time a byte starts to shift out, the block raises event code 3. If the master acknowledges, the next byte sent is the answer to that event, so the bytes of one read arrive in the order the backend returned them.
- R6: When the master does not acknowledge a read byte, the block releases SDA and raises no further event before the STOP. A read of n bytes therefore yields exactly one code 1 event, n code 3 events and one code 4 event.
- R7: A STOP condition raises event code 4 if the target was addressed since the previous STOP. The code 4 event replaces any event still pending. The block then releases SDA and returns to idle.
- R8: A transfer whose address does not match raises no event, including no event for its STOP, and never pulls SDA low.
- R9: A repeated START begins a new address phase without raising code 4.
- R10: While `ev_valid` is high and `ev_ready` is low, `ev_valid` stays high and `ev_code` holds its value, unless a STOP replaces the event with code 4.
- R11: If an event is pending at an SCL falling edge, `scl_pull` holds SCL low until the event is accepted. It is released no more than one cycle after `ev_valid` drops.
- R12: `sda_pull` only asserts while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | ADDR_W | 7-bit address this target answers to |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_pull | output | 1 | Pull SCL low (clock stretch) |
| sda_pull | output | 1 | Pull SDA low (ACK or data 0) |
| ev_valid | output | 1 | Event pending for the backend |
| ev_ready | input | 1 | Backend accepts the pending event |
| ev_code | output | 3 | 0 write request, 1 read request, 2 byte received, 3 next byte wanted, 4 stop |
| ev_data | output | DATA_W | Received byte for code 2, zero otherwise |
| bk_data | input | DATA_W | Byte to transmit, taken when a code 1 or 3 event is accepted |
| bk_nack | input | 1 | 1 rejects the received byte, taken when a code 2 event is accepted |

## Verification
Two functions can act in the same cycle: the byte-received event that is waiting for a slow backend, and a STOP condition that arrives before that event is accepted. The bench provokes this by giving the backend a long response delay. The master ends a byte whose last bit is 0 by raising SDA while SCL is still high, which forms a STOP right after the eighth data bit. The bench first sees code 2 held with the correct byte. It then sees code 4 take its place with SDA released, and finds that the backend log holds only the write request and the stop.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
   typedef enum logic [2:0] {
      EV_WR_REQ  = 3'd0,
      EV_RD_REQ  = 3'd1,
      EV_WR_GOT  = 3'd2,
      EV_RD_NEXT = 3'd3,
      EV_STOP    = 3'd4
   } ev_e;

   typedef enum logic [3:0] {
      S_IDLE, S_ADDR, S_AACK, S_AACK2, S_WDAT,
      S_WACK, S_WACK2, S_RDAT, S_RACK, S_RACK2
   } st_e;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] ff;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) ff[0] <= RESET_VAL;
               else        ff[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) ff[i] <= RESET_VAL;
               else        ff[i] <= ff[i-1];
         end
      end
   endgenerate

   assign q = ff[STAGES-1];
endmodule

// File: rtl/i2ct_linedet.sv
module i2ct_linedet (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   // SDA edges with SCL high on both samples mark bus conditions
   assign start_det =  scl_s & scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s & scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2c_tgt_evt.sv
module i2c_tgt_evt
   import i2ct_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_pull,
   output logic              sda_pull,
   output logic              ev_valid,
   input  logic              ev_ready,
   output logic [2:0]        ev_code,
   output logic [DATA_W-1:0] ev_data,
   input  logic [DATA_W-1:0] bk_data,
   input  logic              bk_nack
);
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W != ADDR_W + 1) begin : g_bad_width
         $error("DATA_W must equal ADDR_W + 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;

   i2ct_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
   i2ct_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

   i2ct_linedet u_det (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   st_e               st;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] shreg, pf, shin;
   logic              rw, sel, fall_pend, nack_q, fall_state;

   assign shin     = {shreg[DATA_W-2:0], sda_s};
   assign scl_pull = fall_pend;

   always_comb
      fall_state = st inside {S_AACK, S_AACK2, S_WACK, S_WACK2, S_RDAT, S_RACK2};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         cnt       <= '0;
         shreg     <= '0;
         pf        <= '0;
         rw        <= 1'b0;
         sel       <= 1'b0;
         fall_pend <= 1'b0;
         nack_q    <= 1'b0;
         sda_pull  <= 1'b0;
         ev_valid  <= 1'b0;
         ev_code   <= EV_WR_REQ;
         ev_data   <= '0;
      end else begin
         // backend acceptance captures its answer
         if (ev_valid && ev_ready) begin
            ev_valid <= 1'b0;
            if (ev_code == EV_RD_REQ || ev_code == EV_RD_NEXT) pf <= bk_data;
            if (ev_code == EV_WR_GOT) nack_q <= bk_nack;
         end

         if (stop_det) begin
            st        <= S_IDLE;
            fall_pend <= 1'b0;
            sda_pull  <= 1'b0;
            sel       <= 1'b0;
            if (sel) begin
               ev_valid <= 1'b1;
               ev_code  <= EV_STOP;
               ev_data  <= '0;
            end
         end else if (start_det) begin
            st        <= S_ADDR;
            cnt       <= '0;
            fall_pend <= 1'b0;
            sda_pull  <= 1'b0;
         end else begin
            if (scl_fall && fall_state) fall_pend <= 1'b1;

            // deferred falling-edge work, once nothing is pending
            if (fall_pend && !ev_valid) begin
               fall_pend <= 1'b0;
               case (st)
                  S_AACK: begin
                     sda_pull <= 1'b1;
                     st       <= S_AACK2;
                  end
                  S_AACK2, S_RACK2: begin
                     if (st == S_RACK2 || rw) begin
                        shreg    <= pf;
                        sda_pull <= ~pf[DATA_W-1];
                        cnt      <= '0;
                        ev_valid <= 1'b1;
                        ev_code  <= EV_RD_NEXT;
                        ev_data  <= '0;
                        st       <= S_RDAT;
                     end else begin
                        sda_pull <= 1'b0;
                        cnt      <= '0;
                        st       <= S_WDAT;
                     end
                  end
                  S_WACK: begin
                     sda_pull <= ~nack_q;
                     st       <= S_WACK2;
                  end
                  S_WACK2: begin
                     sda_pull <= 1'b0;
                     cnt      <= '0;
                     st       <= S_WDAT;
                  end
                  S_RDAT: begin
                     if (cnt == LAST_BIT) begin
                        sda_pull <= 1'b0;
                        st       <= S_RACK;
                     end else begin
                        shreg    <= {shreg[DATA_W-2:0], 1'b0};
                        sda_pull <= ~shreg[DATA_W-2];
                        cnt      <= cnt + 1'b1;
                     end
                  end
                  default: ;
               endcase
            end

            if (scl_rise) begin
               case (st)
                  S_ADDR: begin
                     shreg <= shin;
                     cnt   <= cnt + 1'b1;
                     if (cnt == LAST_BIT) begin
                        if (shin[DATA_W-1:1] == own_addr) begin
                           sel      <= 1'b1;
                           rw       <= shin[0];
                           ev_valid <= 1'b1;
                           ev_code  <= shin[0] ? EV_RD_REQ : EV_WR_REQ;
                           ev_data  <= '0;
                           st       <= S_AACK;
                        end else begin
                           st <= S_IDLE;
                        end
                     end
                  end
                  S_WDAT: begin
                     shreg <= shin;
                     cnt   <= cnt + 1'b1;
                     if (cnt == LAST_BIT) begin
                        ev_valid <= 1'b1;
                        ev_code  <= EV_WR_GOT;
                        ev_data  <= shin;
                        st       <= S_WACK;
                     end
                  end
                  S_RACK: st <= sda_s ? S_IDLE : S_RACK2;
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ev_valid,
   input logic       ev_ready,
   input logic [2:0] ev_code,
   input logic       scl_pull,
   input logic       sda_pull,
   input logic       stop_det,
   input logic       sel,
   input logic       scl_s
);
   a_r10_evt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid && !ev_ready |=> ev_valid && ($stable(ev_code) || ev_code == 3'd4));

   a_r11_stretch_release: assert property (@(posedge clk) disable iff (!rst_n)
      scl_pull && !ev_valid |=> !scl_pull);

   a_r7_stop_event: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det && sel |=> ev_valid && ev_code == 3'd4);

   a_r7_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_pull);

   a_r12_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !scl_s);
endmodule

bind i2c_tgt_evt i2ct_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
   .ev_code(ev_code), .scl_pull(scl_pull), .sda_pull(sda_pull),
   .stop_det(stop_det), .sel(sel), .scl_s(scl_s));

// File: tb/i2c_tgt_evt_tb_top.sv
module i2c_tgt_evt_tb_top;
   localparam int HP = 10;
   localparam logic [6:0] MY_ADDR = 7'h52;

   logic clk = 1'b0, rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1;
   logic scl_pull, sda_pull, ev_valid, bk_nack = 1'b0, ev_ready = 1'b0;
   logic [2:0] ev_code;
   logic [7:0] ev_data, bk_data = 8'h00;
   wire  scl_line = m_scl & ~scl_pull;
   wire  sda_line = m_sda & ~sda_pull;

   int checks = 0, fails = 0, bk_delay = 0, rd_k = 0, ln = 0;
   logic [2:0] lc [64];
   logic [7:0] ld [64];
   bit sda_seen = 1'b0, done = 1'b0;

   always #4 clk = ~clk;

   i2c_tgt_evt dut_i (
      .clk(clk), .rst_n(rst_n), .own_addr(MY_ADDR),
      .scl_in(scl_line), .sda_in(sda_line),
      .scl_pull(scl_pull), .sda_pull(sda_pull),
      .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_code(ev_code),
      .ev_data(ev_data), .bk_data(bk_data), .bk_nack(bk_nack));

   function automatic logic [7:0] rd_fn(int k);
      return 8'((k * 29 + 90) & 255);
   endfunction
   function automatic bit nack_fn(logic [7:0] d);
      return d[3:0] == 4'hF;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // backend model: answers each event after bk_delay cycles
   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         if (ev_ready) begin
            ev_ready = 1'b0;
            cnt = 0;
         end else if (ev_valid) begin
            if (cnt >= bk_delay) begin
               ev_ready = 1'b1;
               if (ln < 64) begin lc[ln] = ev_code; ld[ln] = ev_data; end
               ln++;
               if (ev_code == 3'd1 || ev_code == 3'd3) begin
                  bk_data = rd_fn(rd_k);
                  rd_k++;
               end
               bk_nack = nack_fn(ev_data);
            end else cnt++;
         end else cnt = 0;
         if (sda_pull) sda_seen = 1'b1;
      end
   end

   task automatic hold(int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic wait_high;
      while (scl_line == 1'b0) @(negedge clk);
   endtask
   task automatic m_start;
      m_sda = 1'b0; hold(HP); m_scl = 1'b0; hold(4);
   endtask
   task automatic m_rstart;
      m_sda = 1'b1; hold(HP); m_scl = 1'b1; wait_high; hold(HP);
      m_sda = 1'b0; hold(HP); m_scl = 1'b0; hold(4);
   endtask
   task automatic m_stop;
      m_sda = 1'b0; hold(HP); m_scl = 1'b1; wait_high; hold(HP);
      m_sda = 1'b1; hold(HP);
   endtask
   task automatic m_bit_w(bit b);
      m_sda = b; hold(HP); m_scl = 1'b1; wait_high; hold(HP); m_scl = 1'b0; hold(4);
   endtask
   task automatic m_bit_r(output bit b);
      m_sda = 1'b1; hold(HP); m_scl = 1'b1; wait_high; hold(HP/2);
      b = sda_line; hold(HP/2); m_scl = 1'b0; hold(4);
   endtask
   task automatic m_wbyte(logic [7:0] d, output bit ack);
      for (int i = 7; i >= 0; i--) m_bit_w(d[i]);
      m_bit_r(ack);
   endtask
   task automatic m_rbyte(output logic [7:0] d, input bit nack);
      for (int i = 7; i >= 0; i--) begin
         bit b;
         m_bit_r(b);
         d[i] = b;
      end
      m_bit_w(nack);
   endtask
   task automatic drain;
      hold(4);
      while (ev_valid || ev_ready) @(negedge clk);
      hold(4);
   endtask

   task automatic do_write(int n, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
      logic [7:0] wb [3];
      bit ack;
      wb[0] = b0; wb[1] = b1; wb[2] = b2;
      ln = 0;
      m_start;
      m_wbyte({MY_ADDR, 1'b0}, ack);
      chk(ack == 1'b0, "R2 write address ack", ack, 0);
      for (int j = 0; j < n; j++) begin
         m_wbyte(wb[j], ack);
         chk(ack == nack_fn(wb[j]), "R4 data ack/nack", ack, nack_fn(wb[j]));
      end
      m_stop;
      drain;
      chk(ln == n + 2, "R4 write event count", ln, n + 2);
      chk(lc[0] == 3'd0, "R2 write request code", lc[0], 0);
      for (int j = 0; j < n; j++)
         chk(lc[1+j] == 3'd2 && ld[1+j] == wb[j], "R4 received byte event",
             {lc[1+j], ld[1+j]}, {3'd2, wb[j]});
      chk(lc[n+1] == 3'd4, "R7 stop event", lc[n+1], 4);
   endtask

   task automatic do_read(int n);
      int k0;
      bit ack;
      logic [7:0] d;
      ln = 0;
      k0 = rd_k;
      m_start;
      m_wbyte({MY_ADDR, 1'b1}, ack);
      chk(ack == 1'b0, "R3 read address ack", ack, 0);
      for (int j = 0; j < n; j++) begin
         m_rbyte(d, j == n - 1);
         chk(d == rd_fn(k0 + j), "R5 read byte order", d, rd_fn(k0 + j));
      end
      m_stop;
      drain;
      chk(ln == n + 2, "R6 read event count", ln, n + 2);
      chk(lc[0] == 3'd1, "R3 read request code", lc[0], 1);
      for (int j = 1; j <= n; j++)
         chk(lc[j] == 3'd3, "R5 prefetch event", lc[j], 3);
      chk(lc[n+1] == 3'd4, "R6 stop after nack", lc[n+1], 4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      bit ack;
      logic [7:0] d;
      void'($urandom(32'd2024));
      hold(5);
      rst_n = 1'b1;
      hold(2);
      chk(!sda_pull && !scl_pull && !ev_valid, "R1 reset outputs",
          {sda_pull, scl_pull, ev_valid}, 0);

      // directed write with one accepted and one rejected byte
      bk_delay = 3;
      do_write(2, 8'h3F, 8'h40, 8'h00);

      // directed read of three bytes
      do_read(3);

      // mismatching address stays silent
      ln = 0; sda_seen = 1'b0;
      m_start;
      m_wbyte({7'h13, 1'b0}, ack);
      chk(ack == 1'b1, "R8 foreign address not acked", ack, 1);
      m_wbyte(8'h00, ack);
      chk(ack == 1'b1, "R8 foreign data not acked", ack, 1);
      m_stop;
      drain;
      chk(ln == 0, "R8 no events for foreign transfer", ln, 0);
      chk(!sda_seen, "R8 SDA never pulled", sda_seen, 0);

      // repeated start: write then read without a stop in between
      ln = 0;
      m_start;
      m_wbyte({MY_ADDR, 1'b0}, ack);
      m_wbyte(8'h12, ack);
      m_rstart;
      m_wbyte({MY_ADDR, 1'b1}, ack);
      chk(ack == 1'b0, "R9 address acked after repeated start", ack, 0);
      m_rbyte(d, 1'b1);
      m_stop;
      drain;
      chk(ln == 5, "R9 event count", ln, 5);
      chk(lc[0] == 0 && lc[1] == 2 && lc[2] == 1 && lc[3] == 3 && lc[4] == 4,
          "R9 sequence without inner stop", {lc[0], lc[1], lc[2], lc[3], lc[4]},
          {3'd0, 3'd2, 3'd1, 3'd3, 3'd4});

      // stretch, then stop colliding with a pending received-byte event
      ln = 0;
      bk_delay = 60;
      m_start;
      for (int i = 7; i >= 0; i--) m_bit_w(i == 0 ? 1'b0 : MY_ADDR[i-1]);
      m_sda = 1'b1; hold(HP); m_scl = 1'b1; hold(20);
      chk(scl_line == 1'b0 && scl_pull, "R11 SCL held while pending", scl_line, 0);
      wait_high;
      chk(!ev_valid, "R11 release only after acceptance", ev_valid, 0);
      hold(HP/2);
      chk(sda_line == 1'b0, "R2 address ack under stretch", sda_line, 0);
      hold(HP/2); m_scl = 1'b0; hold(4);
      bk_delay = 300;
      for (int i = 7; i >= 1; i--) m_bit_w(8'hA6 >> i);
      m_sda = 1'b0; hold(HP); m_scl = 1'b1; wait_high; hold(HP);
      chk(ev_valid && ev_code == 3'd2 && ev_data == 8'hA6, "R4 byte event pending",
          {ev_valid, ev_code, ev_data}, {1'b1, 3'd2, 8'hA6});
      hold(30);
      chk(ev_valid && ev_code == 3'd2, "R10 pending event held", ev_code, 2);
      m_sda = 1'b1; hold(HP);
      chk(ev_valid && ev_code == 3'd4, "R7 stop replaces pending event", ev_code, 4);
      chk(!sda_pull, "R7 SDA released after stop", sda_pull, 0);
      bk_delay = 2;
      drain;
      chk(ln == 2 && lc[0] == 0 && lc[1] == 4, "R7 log after collision",
          {ln[3:0], lc[0], lc[1]}, {4'd2, 3'd0, 3'd4});

      // random mix
      for (int it = 0; it < 10; it++) begin
         int n = $urandom_range(1, 3);
         bk_delay = $urandom_range(0, 15);
         if ($urandom_range(0, 1) == 1)
            do_write(n, 8'($urandom), 8'($urandom), 8'($urandom));
         else
            do_read(n);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule